// File: doc/BRIEF.md
# Dual-Input Cascadable Decade/Binary Up Counter

This block is a 4-bit up counter with two count inputs that can trade roles. A count is taken on a rising edge of the count-clock input while the count-enable input is high. A count is also taken on a falling edge of the count-enable input while the count-clock input is low. Because the enable input counts on its falling edge, counters can be chained in ripple fashion. The top bit of one stage drives the enable input of the next stage, whose count-clock input is held low. The next stage then advances each time the earlier stage wraps.

All three external inputs are treated as asynchronous. They pass through a synchronizer into the fast system clock domain, and edges are found by comparing successive synchronized samples. An elaboration-time parameter selects the modulus: decade (0 to 9) or full binary (0 to 15). In decade mode the next-state logic sends every out-of-range code back into the legal range. The clear input forces the count to zero for as long as it is held high.

Top module: `dual_edge_counter`

## Requirements
- R1: A rising edge on `cnt_clk_in` advances `q` by one when `cnt_en_in` was high just before that edge.
- R2: A falling edge on `cnt_en_in` advances `q` by one when `cnt_clk_in` was low just before that edge.
- R3: A falling edge on `cnt_clk_in` and a rising edge on `cnt_en_in` never change `q`. When neither input changes, `q` holds.
- R4: A rising `cnt_clk_in` edge while `cnt_en_in` is low, and a falling `cnt_en_in` edge while `cnt_clk_in` is high, leave `q` unchanged.
- R5: While `clear_in` is high, `q` is 0, and count edges arriving during that time are dropped. The next valid edge after release counts from 0.
- R6: With `MODE` set to decade, `q` steps 0,1,...,9 and wraps to 0, and it never leaves 0..9.
- R7: With `MODE` set to binary, `q` steps 0,1,...,15 and wraps to 0.
- R8: In decade mode the next-state logic maps any code of 9 or above (codes 10 to 15 included) to 0. Any code therefore reaches a legal value within two counts.
- R9: After an input change is first sampled on a rising `clk` edge, `q` shows the resulting count on the third rising `clk` edge after that one. It is unchanged at the second.
- R10: When `q[3]` of a decade stage drives the enable input of a second stage whose count-clock input is tied low, the second stage advances once each time the first wraps from 9 to 0.
- R11: A high `rst` on a rising `clk` edge sets `q` to 0.
- R12: A rising `cnt_clk_in` edge and a falling `cnt_en_in` edge in the same cycle advance `q` by exactly one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| cnt_clk_in | input | 1 | Count input active on its rising edge (asynchronous) |
| cnt_en_in | input | 1 | Count input active on its falling edge (asynchronous) |
| clear_in | input | 1 | Active-high clear of the count (asynchronous) |
| q | output | 4 | Registered count value |

## Verification
Some properties are checked by assertions on every cycle. These are: the decade count stays within 0..9; a cycle with no detected edge produces no count pulse; a count pulse moves the count by exactly one or wraps it from the last code; and a synchronized clear forces zero on the next cycle. Other behaviours can only be shown by bench scenarios. These are: which edge and level combinations count; the exact three-cycle latency; dropping of edges during a clear; coincident edges counting once; recovery from codes 10 to 15; and ripple cascading through the top bit.

// File: rtl/edge_ctr_pkg.sv
package edge_ctr_pkg;
  typedef enum logic {CNT_BINARY = 1'b0, CNT_DECADE = 1'b1} cnt_mode_e;

  localparam int CNT_W = 4;

  function automatic logic [CNT_W-1:0] last_code(cnt_mode_e m);
    return (m == CNT_DECADE) ? CNT_W'(9) : {CNT_W{1'b1}};
  endfunction
endpackage

// File: rtl/ctr_sync.sv
module ctr_sync #(
  parameter int STAGES = 2,
  parameter int W      = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/ctr_edge.sv
module ctr_edge (
  input  logic clk,
  input  logic rst,
  input  logic s_clk,
  input  logic s_en,
  input  logic s_clr,
  output logic step
);
  logic p_clk, p_en;
  logic clk_rise, en_fall;

  // Qualify each edge with the level the other input held just before it
  assign clk_rise = s_clk & ~p_clk & p_en;
  assign en_fall  = ~s_en & p_en & ~p_clk;

  always_ff @(posedge clk) begin
    if (rst) begin
      p_clk <= 1'b0;
      p_en  <= 1'b0;
      step  <= 1'b0;
    end else begin
      p_clk <= s_clk;
      p_en  <= s_en;
      // coincident edges still yield a single pulse
      step  <= (clk_rise | en_fall) & ~s_clr;
    end
  end

  a_r3_quiet_no_step: assert property (@(posedge clk) disable iff (rst)
    (s_clk == p_clk && s_en == p_en) |=> !step);
endmodule

// File: rtl/ctr_next.sv
module ctr_next import edge_ctr_pkg::*; #(
  parameter cnt_mode_e MODE = CNT_DECADE
) (
  input  logic [CNT_W-1:0] cur,
  output logic [CNT_W-1:0] nxt
);
  localparam logic [CNT_W-1:0] LAST = last_code(MODE);

  generate
    if (MODE == CNT_DECADE) begin : g_dec
      // codes at or above the last legal value fold back to zero
      assign nxt = (cur >= LAST) ? '0 : cur + CNT_W'(1);
    end else begin : g_bin
      assign nxt = cur + CNT_W'(1);
    end
  endgenerate
endmodule

// File: rtl/ctr_core.sv
module ctr_core import edge_ctr_pkg::*; #(
  parameter cnt_mode_e MODE = CNT_DECADE
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             step,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] LAST = last_code(MODE);

  logic [CNT_W-1:0] nxt;

  ctr_next #(.MODE(MODE)) u_next (.cur(cnt), .nxt(nxt));

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt <= '0;
    else if (step)   cnt <= nxt;
  end

  a_r6_in_range: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
  a_r1_advance_one: assert property (@(posedge clk) disable iff (rst)
    (step && !clr && cnt != LAST) |=> cnt == $past(cnt) + CNT_W'(1));
  a_r6_r7_wrap: assert property (@(posedge clk) disable iff (rst)
    (step && !clr && cnt == LAST) |=> cnt == '0);
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (!step && !clr) |=> $stable(cnt));
endmodule

// File: rtl/dual_edge_counter.sv
module dual_edge_counter import edge_ctr_pkg::*; #(
  parameter cnt_mode_e MODE        = CNT_DECADE,
  parameter int        SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_clk_in,
  input  logic             cnt_en_in,
  input  logic             clear_in,
  output logic [CNT_W-1:0] q
);
  logic [2:0] s_bus;
  logic       step;

  ctr_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({clear_in, cnt_en_in, cnt_clk_in}),
    .q   (s_bus)
  );

  ctr_edge u_edge (
    .clk   (clk),
    .rst   (rst),
    .s_clk (s_bus[0]),
    .s_en  (s_bus[1]),
    .s_clr (s_bus[2]),
    .step  (step)
  );

  ctr_core #(.MODE(MODE)) u_core (
    .clk  (clk),
    .rst  (rst),
    .clr  (s_bus[2]),
    .step (step),
    .cnt  (q)
  );

  a_r5_clear_zero: assert property (@(posedge clk) disable iff (rst)
    s_bus[2] |=> q == '0);
endmodule

// File: tb/dual_edge_counter_bench.sv
module dual_edge_counter_bench;
  import edge_ctr_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ci = 1'b0, ei = 1'b0, cl = 1'b0;
  logic [3:0] q_dec, q_bin, q_casc;
  logic [3:0] nx_cur, nx_out, nx_out2;
  int total = 0, bad = 0;
  int e_dec = 0, e_bin = 0, e_casc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dual_edge_counter #(.MODE(CNT_DECADE)) u_dual_edge_counter (
    .clk(clk), .rst(rst), .cnt_clk_in(ci), .cnt_en_in(ei), .clear_in(cl), .q(q_dec));
  dual_edge_counter #(.MODE(CNT_BINARY)) u_dual_edge_counter_bin (
    .clk(clk), .rst(rst), .cnt_clk_in(ci), .cnt_en_in(ei), .clear_in(cl), .q(q_bin));
  dual_edge_counter #(.MODE(CNT_DECADE)) u_dual_edge_counter_casc (
    .clk(clk), .rst(rst), .cnt_clk_in(1'b0), .cnt_en_in(q_dec[3]), .clear_in(cl), .q(q_casc));
  ctr_next #(.MODE(CNT_DECADE)) u_nx  (.cur(nx_cur), .nxt(nx_out));
  ctr_next #(.MODE(CNT_DECADE)) u_nx2 (.cur(nx_out), .nxt(nx_out2));

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic bump();
    if (e_dec == 9) e_casc = (e_casc + 1) % 10;
    e_dec = (e_dec + 1) % 10;
    e_bin = (e_bin + 1) % 16;
  endtask

  task automatic check_both(string tag);
    check({tag, " dec"}, int'(q_dec), e_dec);
    check({tag, " bin"}, int'(q_bin), e_bin);
  endtask

  initial begin : watchdog
    #(4 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    wait_cyc(5);
    check_both("R11 reset");
    check("R11 reset casc", int'(q_casc), 0);
    rst = 1'b0;
    wait_cyc(2);

    // rising enable with clock low: no count
    ei = 1'b1; wait_cyc(6); check_both("R3 en rise");
    // rising clock with enable high
    ci = 1'b1; wait_cyc(6); bump(); check_both("R1 clk rise");
    // falling clock
    ci = 1'b0; wait_cyc(6); check_both("R3 clk fall");

    // latency: one count
    ci = 1'b1;
    @(posedge clk); @(posedge clk); @(posedge clk); @(negedge clk);
    check_both("R9 before");
    @(posedge clk); @(negedge clk); bump();
    check_both("R9 after");
    ci = 1'b0; wait_cyc(6);

    // falling enable with clock low
    ei = 1'b0; wait_cyc(6); bump(); check_both("R2 en fall");
    ei = 1'b1; wait_cyc(6); check_both("R3 en rise2");

    // blocked combinations
    ei = 1'b0; wait_cyc(6); bump();              // counts (clock low)
    ci = 1'b1; wait_cyc(6); check_both("R4 clk rise en low");
    ei = 1'b1; wait_cyc(6); check_both("R4 en rise clk high");
    ei = 1'b0; wait_cyc(6); check_both("R4 en fall clk high");
    ci = 1'b0; wait_cyc(6); check_both("R4 clk fall");

    // coincident edges: clock rises and enable falls together
    ei = 1'b1; wait_cyc(6);
    ci = 1'b1; ei = 1'b0; wait_cyc(6); bump(); check_both("R12 coincident");
    ci = 1'b0; wait_cyc(6); check_both("R12 settle");

    // full sweep through both wraps using clock pulses
    ei = 1'b1; wait_cyc(6);
    for (int k = 0; k < 34; k++) begin
      ci = 1'b1; wait_cyc(6); bump();
      check({"R6 R7 sweep"}, int'(q_dec), e_dec);
      check({"R7 sweep"}, int'(q_bin), e_bin);
      ci = 1'b0; wait_cyc(6);
    end
    check("R10 cascade", int'(q_casc), e_casc);

    // clear: held, with edges arriving during it
    cl = 1'b1; wait_cyc(4);
    ci = 1'b1; wait_cyc(6); ci = 1'b0; wait_cyc(4);
    e_dec = 0; e_bin = 0; e_casc = 0;
    check_both("R5 clear held");
    check("R5 clear casc", int'(q_casc), 0);
    cl = 1'b0; wait_cyc(6); check_both("R5 after release");
    ci = 1'b1; wait_cyc(6); bump(); check_both("R5 first count");
    ci = 1'b0; wait_cyc(6);

    // decade next-state over every code
    for (int c = 0; c < 16; c++) begin
      nx_cur = 4'(c);
      #1;
      check("R8 next", int'(nx_out), (c < 9) ? c + 1 : 0);
      total++;
      if (nx_out2 > 4'd9) begin
        bad++;
        $display("FAIL R8 two-step actual=%0d expected<=9", nx_out2);
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule